// File: doc/BRIEF.md
# Security Register Lock Controller

This block keeps a small bank of security-critical registers (key material, integrity words) together with a lock configuration word. The lock word holds one read lock and one write lock for each register. Boot software reaches both the registers and the lock word through a request/response register bus. Boot software sets the locks it needs early in start-up. From then on, a denied access is answered with an error response and a one-cycle violation pulse. The hardware consumers read the register contents directly on a wide output bus.

Lock bits can be set but never cleared by software. Only the active-low asynchronous power-on reset returns them to the unlocked state. The debug-unlock and scan-mode inputs reach the block but are kept out of both the lock reset path and the permission logic. Entering either mode therefore neither clears nor bypasses a lock.

The request channel uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending, or when the pending response is being consumed in the same cycle (`rsp_ready` high). Each request produces exactly one response, one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and no new request is accepted.

Top module: `sec_lock_ctrl`

## Requirements
- R1: After reset, every protected register reads zero, the lock word reads zero, `rd_allow` and `wr_allow` are all ones, and `rsp_valid` and `access_viol` are low.
- R2: Address encoding: `req_addr[3]`=1 selects the lock word, and `req_addr[3]`=0 selects protected register `req_addr[2:0]`. Lock word bit i (i in 0..7) is the write lock of register i, and bit 8+i is its read lock. A write to the lock word ORs `req_wdata[15:0]` into it, so writing zeros never clears a set bit. Lock word accesses never fail.
- R3: A write to a register whose write lock is set leaves that register unchanged and answers with `rsp_err`=1.
- R4: A read of a register whose read lock is set returns all zeros with `rsp_err`=1.
- R5: An access to an unlocked register succeeds with `rsp_err`=0. A write stores `req_wdata`, a read returns the stored value, and a write response carries zero data.
- R6: `dbg_unlock` and `scan_mode` have no effect on the lock word, on access decisions or on register contents.
- R7: `rd_allow[i]` is the inverse of register i's read lock, and `wr_allow[i]` is the inverse of its write lock. Neither ever rises between resets.
- R8: The response comes one cycle after acceptance. `req_ready` = !`rsp_valid` || `rsp_ready`. A stalled response holds `rsp_rdata` and `rsp_err` stable.
- R9: `access_viol` is high for exactly the first cycle of every error response, and never otherwise.
- R10: `key_bus[32*i +: 32]` always shows the contents of protected register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Bit 3 selects the lock word, bits 2:0 select a register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Read data (zero for writes and denied reads) |
| rsp_err | output | 1 | Access was denied by a lock |
| access_viol | output | 1 | One-cycle pulse per denied access |
| rd_allow | output | 8 | Per-register read permission |
| wr_allow | output | 8 | Per-register write permission |
| key_bus | output | 256 | Contents of all protected registers |
| dbg_unlock | input | 1 | Debug-unlock indication, has no influence on locks |
| scan_mode | input | 1 | Scan-mode indication, has no influence on locks |

## Verification
On every cycle, the assertions check several properties:
- the permission outputs never re-open;
- a write blocked by a lock leaves the register bus untouched;
- a blocked read answers with zero data and an error;
- a stalled response holds still;
- each violation pulse sits on an error response.

Other behaviour only shows up in the bench scenarios:
- the values stored and read back;
- the OR-only update of the lock word;
- the indifference of the block to debug and scan activity while locked and unlocked registers are accessed in mixed random order.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_LOCKCFG = 2'd1,
    ACC_GRANTED = 2'd2,
    ACC_DENIED  = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/slc_lock_store.sv
module slc_lock_store #(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [2*NUM_REGS-1:0] set_bits,
  output logic [2*NUM_REGS-1:0] lock_q
);

  // Only power-on reset clears; software can only add bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (set_en) begin
      lock_q <= lock_q | set_bits;
    end
  end

endmodule

// File: rtl/slc_reg_bank.sv
module slc_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REGS-1:0]        wr_sel,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_sel[g]) begin
        q <= wdata;
      end
    end
    assign regs_flat[g*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/slc_access_gate.sv
module slc_access_gate
  import sec_lock_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int ADDR_W   = IDX_W + 1
) (
  input  logic                       fire,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [2*NUM_REGS-1:0]      lock_q,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic                       lock_set_en,
  output logic [2*NUM_REGS-1:0]      lock_set_bits,
  output logic [NUM_REGS-1:0]        reg_wr_sel,
  output logic [DATA_W-1:0]          rdata,
  output acc_kind_e                  kind
);

  logic [IDX_W-1:0] idx;
  logic             is_cfg;
  logic             rd_locked;
  logic             wr_locked;

  assign idx           = addr[IDX_W-1:0];
  assign is_cfg        = addr[ADDR_W-1];
  // Permission depends on the lock word alone; no mode input reaches here.
  assign wr_locked     = lock_q[idx];
  assign rd_locked     = lock_q[NUM_REGS + int'(idx)];
  assign lock_set_bits = wdata[2*NUM_REGS-1:0];

  always_comb begin
    kind        = ACC_IDLE;
    lock_set_en = 1'b0;
    reg_wr_sel  = '0;
    rdata       = '0;
    if (fire) begin
      if (is_cfg) begin
        kind = ACC_LOCKCFG;
        if (we) begin
          lock_set_en = 1'b1;
        end else begin
          rdata[2*NUM_REGS-1:0] = lock_q;
        end
      end else if (we) begin
        if (wr_locked) begin
          kind = ACC_DENIED;
        end else begin
          kind            = ACC_GRANTED;
          reg_wr_sel[idx] = 1'b1;
        end
      end else begin
        if (rd_locked) begin
          kind = ACC_DENIED;
        end else begin
          kind  = ACC_GRANTED;
          rdata = regs_flat[int'(idx)*DATA_W +: DATA_W];
        end
      end
    end
  end

endmodule

// File: rtl/sec_lock_ctrl.sv
module sec_lock_ctrl
  import sec_lock_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int ADDR_W   = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       rsp_err,
  output logic                       access_viol,
  output logic [NUM_REGS-1:0]        rd_allow,
  output logic [NUM_REGS-1:0]        wr_allow,
  output logic [NUM_REGS*DATA_W-1:0] key_bus,
  input  logic                       dbg_unlock,
  input  logic                       scan_mode
);

  logic                       fire;
  logic [2*NUM_REGS-1:0]      lock_q;
  logic                       lock_set_en;
  logic [2*NUM_REGS-1:0]      lock_set_bits;
  logic [NUM_REGS-1:0]        reg_wr_sel;
  logic [DATA_W-1:0]          rdata_c;
  acc_kind_e                  kind;

  // Mode inputs are intentionally left without any fan-out into locks.
  logic unused_mode_inputs;
  assign unused_mode_inputs = &{1'b0, dbg_unlock, scan_mode};

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  slc_lock_store #(.NUM_REGS(NUM_REGS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (lock_set_en),
    .set_bits (lock_set_bits),
    .lock_q   (lock_q)
  );

  slc_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (reg_wr_sel),
    .wdata     (req_wdata),
    .regs_flat (key_bus)
  );

  slc_access_gate #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W)
  ) u_gate (
    .fire          (fire),
    .we            (req_write),
    .addr          (req_addr),
    .wdata         (req_wdata),
    .lock_q        (lock_q),
    .regs_flat     (key_bus),
    .lock_set_en   (lock_set_en),
    .lock_set_bits (lock_set_bits),
    .reg_wr_sel    (reg_wr_sel),
    .rdata         (rdata_c),
    .kind          (kind)
  );

  assign wr_allow = ~lock_q[NUM_REGS-1:0];
  assign rd_allow = ~lock_q[2*NUM_REGS-1:NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      access_viol <= 1'b0;
    end else begin
      access_viol <= (kind == ACC_DENIED);
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_err   <= (kind == ACC_DENIED);
        rsp_rdata <= req_write ? '0 : rdata_c;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sec_lock_ctrl_chk.sv
module sec_lock_ctrl_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic                       rsp_err,
  input logic                       access_viol,
  input logic [NUM_REGS-1:0]        rd_allow,
  input logic [NUM_REGS-1:0]        wr_allow,
  input logic [NUM_REGS*DATA_W-1:0] key_bus
);

  logic             acc;
  logic [ADDR_W-2:0] idx;
  assign acc = req_valid && req_ready && !req_addr[ADDR_W-1];
  assign idx = req_addr[ADDR_W-2:0];

  p_wr_allow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wr_allow & ~$past(wr_allow)) == '0));

  p_rd_allow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_allow & ~$past(rd_allow)) == '0));

  p_locked_write_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !wr_allow[idx]) |=> ($stable(key_bus) && rsp_valid && rsp_err));

  p_locked_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !rd_allow[idx]) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_viol_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    access_viol |-> (rsp_valid && rsp_err));

endmodule

bind sec_lock_ctrl sec_lock_ctrl_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .access_viol (access_viol),
  .rd_allow    (rd_allow),
  .wr_allow    (wr_allow),
  .key_bus     (key_bus)
);

// File: tb/sec_lock_ctrl_tb.sv
module sec_lock_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int AW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_write = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [W-1:0]   req_wdata = '0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b1;
  logic [W-1:0]   rsp_rdata;
  logic           rsp_err;
  logic           access_viol;
  logic [N-1:0]   rd_allow;
  logic [N-1:0]   wr_allow;
  logic [N*W-1:0] key_bus;
  logic           dbg_unlock = 1'b0;
  logic           scan_mode = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0]   exp_reg [N];
  logic [2*N-1:0] exp_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .access_viol(access_viol), .rd_allow(rd_allow),
    .wr_allow(wr_allow), .key_bus(key_bus), .dbg_unlock(dbg_unlock),
    .scan_mode(scan_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_rdata(input bit wr, input logic [AW-1:0] a);
    if (wr) return '0;
    if (a[3]) return {{(W-2*N){1'b0}}, exp_lock};
    if (exp_lock[N + int'(a[2:0])]) return '0;
    return exp_reg[a[2:0]];
  endfunction

  function automatic bit exp_error(input bit wr, input logic [AW-1:0] a);
    if (a[3]) return 1'b0;
    return wr ? exp_lock[a[2:0]] : exp_lock[N + int'(a[2:0])];
  endfunction

  function automatic logic [N*W-1:0] exp_keys();
    logic [N*W-1:0] k;
    for (int i = 0; i < N; i++) k[i*W +: W] = exp_reg[i];
    return k;
  endfunction

  task automatic model_update(input bit wr, input logic [AW-1:0] a, input logic [W-1:0] d);
    if (!wr) return;
    if (a[3]) exp_lock = exp_lock | d[2*N-1:0];
    else if (!exp_lock[a[2:0]]) exp_reg[a[2:0]] = d;
  endtask

  // Issue one access and check the response one cycle after acceptance.
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [W-1:0] d,
                        input string tag);
    logic [W-1:0] er;
    bit ee;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    chk(req_ready == 1'b1, "R8 ready when idle", {255'd0, req_ready}, 256'd1);
    er = exp_rdata(wr, a);
    ee = exp_error(wr, a);
    model_update(wr, a, d);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, {255'd0, rsp_valid}, 256'd1);
    chk(rsp_rdata == er, {tag, " rdata"}, {224'd0, rsp_rdata}, {224'd0, er});
    chk(rsp_err == ee, {tag, " err"}, {255'd0, rsp_err}, {255'd0, ee});
    chk(access_viol == ee, "R9 viol pulse", {255'd0, access_viol}, {255'd0, ee});
    chk(wr_allow == ~exp_lock[N-1:0] && rd_allow == ~exp_lock[2*N-1:N], "R7 allow",
        {240'd0, rd_allow, wr_allow}, {240'd0, ~exp_lock[2*N-1:N], ~exp_lock[N-1:0]});
    chk(key_bus == exp_keys(), "R10 key_bus", key_bus, exp_keys());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC1_0C4D));
    for (int i = 0; i < N; i++) exp_reg[i] = '0;
    exp_lock = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 0 && access_viol == 0, "R1 rsp idle", {254'd0, rsp_valid, access_viol}, 256'd0);
    chk(rd_allow == '1 && wr_allow == '1, "R1 allow", {240'd0, rd_allow, wr_allow}, {240'd0, 16'hFFFF});
    chk(key_bus == '0, "R1 regs zero", key_bus, 256'd0);
    rst_n = 1'b1;
    access(0, 4'h8, '0, "R1 lock word zero");

    // R5 unlocked write/read on every register
    for (int i = 0; i < N; i++) access(1, AW'(i), 32'hA5A5_0000 + i, "R5 write");
    for (int i = 0; i < N; i++) access(0, AW'(i), '0, "R5 read");

    // Lock: write lock on reg 2 (bit 2), read lock on reg 5 (bit 13)
    access(1, 4'h8, 32'h0000_2004, "R2 set locks");
    access(0, 4'h8, '0, "R2 lock readback");
    access(1, 4'h2, 32'hDEAD_BEEF, "R3 locked write");
    access(0, 4'h2, '0, "R5 readable write-locked reg");
    access(0, 4'h5, '0, "R4 locked read");
    access(1, 4'h5, 32'h1234_5678, "R5 write to read-locked reg");

    // R6 debug and scan modes change nothing
    dbg_unlock = 1'b1; scan_mode = 1'b1;
    access(1, 4'h2, 32'hCAFE_F00D, "R6 write under debug+scan");
    access(0, 4'h5, '0, "R6 read under debug+scan");
    dbg_unlock = 1'b1; scan_mode = 1'b0;
    access(1, 4'h8, 32'h0, "R6 R2 zero write under debug");
    access(0, 4'h8, '0, "R6 R2 lock sticky");
    dbg_unlock = 1'b0;

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_rdata == exp_reg[1], "R8 stalled rsp", {224'd0, rsp_rdata}, {224'd0, exp_reg[1]});
    chk(req_ready == 1'b0, "R8 ready low while stalled", {255'd0, req_ready}, 256'd0);
    req_valid = 1'b1; req_addr = 4'h3;
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_rdata == exp_reg[1] && rsp_err == 0, "R8 held",
        {224'd0, rsp_rdata}, {224'd0, exp_reg[1]});
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 consumed", {255'd0, rsp_valid}, 256'd0);

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  d;
      bit wr;
      dbg_unlock = 1'($urandom);
      scan_mode  = 1'($urandom);
      wr = 1'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        a = 4'h8;
        d = $urandom & $urandom & $urandom;
      end else begin
        a = AW'($urandom_range(0, N-1));
        d = $urandom;
      end
      access(wr, a, d, "R2-mix random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule